// File: doc/BRIEF.md
# Push-All Register Stack Sequencer

This block performs a "save every general-purpose register to the stack" operation as a short micro-sequence. On a start pulse it checks the decoded opcode and the processor mode. If the request is legal, it captures a snapshot of the eight registers, which include the stack pointer. It then emits one memory write per register through a valid/ready write port. Before each write the stack pointer drops by the operand size, and the datum lands at the new pointer. When the eighth write is accepted, the block reports the final stack pointer together with a one-cycle done pulse. The operand-size input selects full 32-bit words or 16-bit low halves. The same opcode value serves both widths.

The write port follows valid/ready rules. `wr_valid_o` rises one cycle after an accepted start. While it is high and `wr_ready_i` is low, address, data and byte enables hold still. A write is taken on any rising edge where both signals are high, and the next write, if any, is presented on the following cycle. The memory side may stall for any number of cycles. When long mode is active, the request is refused with a one-cycle fault pulse, and no write is issued.

Top module: `gpr_push_seq`

## Requirements
- R1: Writes go out in slot order 0..7 of `gpr_i`. The slots are: 0 accumulator, 1 counter, 2 data, 3 base, 4 stack pointer, 5 base pointer, 6 source index, 7 destination index.
- R2: The write for slot 4 carries the stack pointer as it was at the start request, not any decremented value.
- R3: With `opsz32_i`=1 the data is the full 32-bit register and `wr_be_o`=4'b1111. With `opsz32_i`=0 the data is the low 16 bits in `wr_data_o[15:0]`, the upper bits are zero, and `wr_be_o`=4'b0011.
- R4: Write k (k=0..7) uses address SP0-(k+1)*S, where SP0 is the stack pointer at start and S is 4 (32-bit) or 2 (16-bit). Arithmetic wraps modulo 2^32.
- R5: `done_o` is high for exactly the one cycle after the eighth accepted write. In that cycle `sp_o`=SP0-8*S, and `wr_valid_o` and `busy_o` are low.
- R6: While `wr_valid_o`=1 and `wr_ready_i`=0, the next cycle keeps `wr_valid_o`=1 with address, data and byte enables unchanged.
- R7: A start whose opcode is not 8'h60 is ignored: no write, no fault, `busy_o` stays 0.
- R8: A start with opcode 8'h60 while `long_mode_i`=1 raises `fault_o` for one cycle, issues no write, never raises `done_o`, and sets `sp_o` to the unchanged input stack pointer.
- R9: A start while a sequence runs is ignored. The running sequence keeps its addresses and data and ends after exactly eight writes.
- R10: During and right after reset, `wr_valid_o`, `busy_o`, `done_o` and `fault_o` are 0.
- R11: Register values are captured at the accepted start. Later changes on `gpr_i` do not alter any write of that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, sampled while idle |
| opcode_i | input | 8 | Decoded opcode byte |
| long_mode_i | input | 1 | 1 when 64-bit mode is active |
| opsz32_i | input | 1 | 1 = 32-bit operands, 0 = 16-bit |
| gpr_i | input | 8x32 | Register snapshot, slot numbering as in R1 |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Memory side accepts the write |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_be_o | output | 4 | Byte enables |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle invalid-opcode pulse |
| sp_o | output | 32 | Final (or unchanged on fault) stack pointer |

## Verification
An error in the slot counter or the pointer register shows at the port on the very next accepted write, as a wrong address or a datum from the wrong slot. A miscounted terminal slot shows as a done pulse after seven or nine writes. A snapshot that was not latched, or was latched late, shows as altered data, because the bench inverts `gpr_i` right after the start. The stall patterns exercise every write under back-pressure. A lost hold shows in the first stalled cycle.

// File: rtl/gps_pkg.sv
package gps_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_PUSH = 1'b1
  } gps_state_e;

  function automatic int unsigned gps_step(input logic wide, input int unsigned dw);
    return wide ? dw / 8 : dw / 16;
  endfunction
endpackage

// File: rtl/gps_ctrl.sv
module gps_ctrl
  import gps_pkg::*;
#(
  parameter int unsigned NREGS  = 8,
  parameter int unsigned OPW    = 8,
  parameter logic [OPW-1:0] OPCODE = 8'h60,
  localparam int unsigned SW = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [OPW-1:0] opcode_i,
  input  logic          long_mode_i,
  input  logic          hs_i,
  output logic          launch_o,
  output logic          refuse_o,
  output logic          busy_o,
  output logic          last_o,
  output logic [SW-1:0] slot_o,
  output logic          done_o,
  output logic          fault_o
);
  gps_state_e state_q;
  logic [SW-1:0] slot_q;
  logic done_q, fault_q;
  logic req_ok;

  assign req_ok   = (state_q == ST_IDLE) && start_i && (opcode_i == OPCODE);
  assign launch_o = req_ok && !long_mode_i;
  assign refuse_o = req_ok && long_mode_i;
  assign busy_o   = (state_q == ST_PUSH);
  assign last_o   = (slot_q == SW'(NREGS - 1));
  assign slot_o   = slot_q;
  assign done_o   = done_q;
  assign fault_o  = fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= refuse_o;
      case (state_q)
        ST_IDLE: begin
          if (launch_o) begin
            state_q <= ST_PUSH;
            slot_q  <= '0;
          end
        end
        ST_PUSH: begin
          if (hs_i) begin
            if (last_o) begin
              state_q <= ST_IDLE;
              slot_q  <= '0;
              done_q  <= 1'b1;
            end else begin
              slot_q <= slot_q + SW'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));
  p_fault_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !busy_o);
  p_slot_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !hs_i) |=> (busy_o && $stable(slot_o)));
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !(hs_i && last_o)) |=> (busy_o && !done_o));
endmodule

// File: rtl/gps_sp_track.sv
module gps_sp_track
  import gps_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch_i,
  input  logic          refuse_i,
  input  logic          wide_i,
  input  logic [DW-1:0] sp_in_i,
  input  logic          hs_i,
  input  logic          last_i,
  output logic          wide_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] sp_o
);
  logic [DW-1:0] cur_q, fin_q;
  logic          wide_q;
  logic [DW-1:0] step_new, step_run;

  assign step_new = DW'(gps_step(wide_i, DW));
  assign step_run = DW'(gps_step(wide_q, DW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      fin_q  <= '0;
      wide_q <= 1'b0;
    end else begin
      if (launch_i) begin
        cur_q  <= sp_in_i - step_new;
        wide_q <= wide_i;
      end else if (hs_i) begin
        if (last_i) fin_q <= cur_q;
        else        cur_q <= cur_q - step_run;
      end
      if (refuse_i) fin_q <= sp_in_i;
    end
  end

  assign wide_o = wide_q;
  assign addr_o = cur_q;
  assign sp_o   = fin_q;
endmodule

// File: rtl/gps_lane_pack.sv
module gps_lane_pack #(
  parameter int unsigned DW    = 32,
  parameter int unsigned NREGS = 8,
  localparam int unsigned SW = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int unsigned NB = DW / 8,
  localparam int unsigned HB = DW / 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch_i,
  input  logic [NREGS-1:0][DW-1:0]   gpr_i,
  input  logic [SW-1:0]              slot_i,
  input  logic                       wide_i,
  input  logic                       valid_i,
  output logic [DW-1:0]              data_o,
  output logic [NB-1:0]              be_o
);
  logic [NREGS-1:0][DW-1:0] snap_q;
  logic [DW-1:0] pick;

  for (genvar g = 0; g < NREGS; g++) begin : g_snap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        snap_q[g] <= '0;
      else if (launch_i) snap_q[g] <= gpr_i[g];
    end
  end

  assign pick = snap_q[slot_i];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    if (b < HB) begin : g_low
      assign be_o[b] = 1'b1;
    end else begin : g_high
      assign be_o[b] = wide_i;
    end
    assign data_o[8*b +: 8] = be_o[b] ? pick[8*b +: 8] : 8'h00;
  end

  p_be_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |-> (be_o == {NB{1'b1}} || be_o == NB'((1 << HB) - 1)));
endmodule

// File: rtl/gpr_push_seq.sv
module gpr_push_seq #(
  parameter int unsigned DW      = 32,
  parameter int unsigned NREGS   = 8,
  parameter int unsigned SP_SLOT = 4,
  parameter logic [7:0]  OPCODE  = 8'h60,
  localparam int unsigned SW = (NREGS > 1) ? $clog2(NREGS) : 1,
  localparam int unsigned NB = DW / 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [7:0]               opcode_i,
  input  logic                     long_mode_i,
  input  logic                     opsz32_i,
  input  logic [NREGS-1:0][DW-1:0] gpr_i,
  output logic                     wr_valid_o,
  input  logic                     wr_ready_i,
  output logic [DW-1:0]            wr_addr_o,
  output logic [DW-1:0]            wr_data_o,
  output logic [NB-1:0]            wr_be_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     fault_o,
  output logic [DW-1:0]            sp_o
);
  logic launch, refuse, busy, last, hs, wide;
  logic [SW-1:0] slot;

  assign hs         = busy && wr_ready_i;
  assign wr_valid_o = busy;
  assign busy_o     = busy;

  gps_ctrl #(.NREGS(NREGS), .OPW(8), .OPCODE(OPCODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
    .long_mode_i(long_mode_i), .hs_i(hs), .launch_o(launch), .refuse_o(refuse),
    .busy_o(busy), .last_o(last), .slot_o(slot), .done_o(done_o), .fault_o(fault_o)
  );

  gps_sp_track #(.DW(DW)) u_sp (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .refuse_i(refuse),
    .wide_i(opsz32_i), .sp_in_i(gpr_i[SP_SLOT]), .hs_i(hs), .last_i(last),
    .wide_o(wide), .addr_o(wr_addr_o), .sp_o(sp_o)
  );

  gps_lane_pack #(.DW(DW), .NREGS(NREGS)) u_pack (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .gpr_i(gpr_i), .slot_i(slot),
    .wide_i(wide), .valid_i(busy), .data_o(wr_data_o), .be_o(wr_be_o)
  );

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o) && $stable(wr_be_o)));
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && wr_ready_i && wr_valid_o && !done_o) ##1 wr_valid_o |->
      (wr_addr_o == $past(wr_addr_o) - ($past(wr_be_o[NB-1]) ? DW'(DW/8) : DW'(DW/16))));
  p_done_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(wr_valid_o && wr_ready_i) && !wr_valid_o));
  p_fault_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !wr_valid_o);
endmodule

// File: tb/tb_gpr_push_seq.sv
`timescale 1ns/1ps
module tb_gpr_push_seq;
  localparam int DW = 32;
  localparam int NR = 8;

  typedef struct packed {
    logic        w;
    logic [1:0]  pat;
    logic        poke;
    logic [31:0] sp;
    logic [31:0] seed;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd0, 1'b0, 32'h0000_8000, 32'hA5A5_0001},
    '{1'b0, 2'd0, 1'b0, 32'h0000_2000, 32'h1234_ABCD},
    '{1'b1, 2'd1, 1'b0, 32'h7FFF_FFF0, 32'h0F0F_3C3C},
    '{1'b0, 2'd2, 1'b0, 32'h0001_0004, 32'hDEAD_BEEF},
    '{1'b1, 2'd3, 1'b1, 32'h0000_0010, 32'h5555_AAAA},
    '{1'b0, 2'd3, 1'b1, 32'h0000_0008, 32'h8001_7FFE}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 1'b0, lm = 1'b0, w32 = 1'b0, rdy = 1'b0;
  logic [7:0] opc = 8'h00;
  logic [NR-1:0][DW-1:0] gpr = '0;
  logic wr_valid, done, fault, busy;
  logic [DW-1:0] wr_addr, wr_data, sp_out;
  logic [3:0] wr_be;

  int errs = 0;
  int checks = 0;
  bit ended = 1'b0;

  gpr_push_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .opcode_i(opc), .long_mode_i(lm),
    .opsz32_i(w32), .gpr_i(gpr), .wr_valid_o(wr_valid), .wr_ready_i(rdy),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_be_o(wr_be), .busy_o(busy),
    .done_o(done), .fault_o(fault), .sp_o(sp_out)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] regv(input logic [31:0] seed, input int k);
    return seed ^ (32'h1357_9BDF * 32'(k + 1));
  endfunction

  function automatic bit rdy_at(input logic [1:0] pat, input int c);
    case (pat)
      2'd0: return 1'b1;
      2'd1: return c[0];
      2'd2: return (c % 3) == 2;
      default: return c >= 4;
    endcase
  endfunction

  task automatic run_seq(input vec_t v);
    int n = 0;
    int c = 0;
    bit got_done = 1'b0;
    bit pend = 1'b0;
    logic [31:0] pa = '0, pd = '0;
    logic [3:0] pb = '0;
    logic [31:0] step = v.w ? 32'd4 : 32'd2;
    @(negedge clk);
    w32 = v.w; lm = 1'b0; opc = 8'h60; rdy = 1'b0;
    for (int k = 0; k < NR; k++) gpr[k] = (k == 4) ? v.sp : regv(v.seed, k);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gpr = ~gpr;  // R11: later input changes must not reach the writes
    while (c < 300 && !got_done) begin
      if (done) begin
        got_done = 1'b1;
        chk("R5", "write count at done", 32'(n), 32'd8);
        chk("R5", "final sp", sp_out, v.sp - 32'd8 * step);
        chk("R5", "valid low at done", {31'd0, wr_valid}, 32'd0);
      end else begin
        if (pend) begin
          chk("R6", "valid held", {31'd0, wr_valid}, 32'd1);
          chk("R6", "addr held", wr_addr, pa);
          chk("R6", "data held", wr_data, pd);
          chk("R6", "be held", {28'd0, wr_be}, {28'd0, pb});
        end
        rdy = rdy_at(v.pat, c);
        start = (v.poke && c == 2);  // R9: start while busy
        if (start) begin opc = 8'h60; gpr[4] = 32'hCAFE_0000; end
        pend = 1'b0;
        if (wr_valid) begin
          if (rdy) begin
            logic [31:0] val;
            val = (n == 4) ? v.sp : regv(v.seed, n);
            chk("R4", "address", wr_addr, v.sp - step * 32'(n + 1));
            if (n == 4) chk("R2", "sp slot data", wr_data, v.w ? val : {16'h0, val[15:0]});
            else        chk("R1", "slot data", wr_data, v.w ? val : {16'h0, val[15:0]});
            chk("R3", "byte enables", {28'd0, wr_be}, v.w ? 32'hF : 32'h3);
            n++;
          end else begin
            pend = 1'b1; pa = wr_addr; pd = wr_data; pb = wr_be;
          end
        end
      end
      if (!got_done) begin
        @(negedge clk);
        c++;
      end
    end
    start = 1'b0; rdy = 1'b0;
    if (!got_done) chk("R5", "done seen", 32'd0, 32'd1);
    @(negedge clk);
    chk("R5", "done is one cycle", {31'd0, done}, 32'd0);
    chk("R9", "idle after eight writes", {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "valid in reset", {31'd0, wr_valid}, 32'd0);
    chk("R10", "busy in reset", {31'd0, busy}, 32'd0);
    chk("R10", "done/fault in reset", {30'd0, done, fault}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "valid after reset", {31'd0, wr_valid}, 32'd0);

    for (int i = 0; i < NV; i++) run_seq(VECS[i]);

    // R8: long mode refusal
    @(negedge clk);
    lm = 1'b1; opc = 8'h60; w32 = 1'b1; gpr[4] = 32'h1234_5678; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", "fault pulse", {31'd0, fault}, 32'd1);
    chk("R8", "no write", {31'd0, wr_valid}, 32'd0);
    chk("R8", "sp unchanged", sp_out, 32'h1234_5678);
    @(negedge clk);
    chk("R8", "fault one cycle", {31'd0, fault}, 32'd0);
    chk("R8", "no write later", {30'd0, wr_valid, done}, 32'd0);

    // R7: wrong opcode, in both modes
    for (int m = 0; m < 2; m++) begin
      @(negedge clk);
      lm = m[0]; opc = 8'h61; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 3; k++) begin
        chk("R7", "ignored opcode", {29'd0, busy, wr_valid, fault}, 32'd0);
        @(negedge clk);
      end
    end

    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!ended) begin
      ended = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule